// File: doc/BRIEF.md
# Bit-Sliced Arithmetic Logic Unit with Set-Less-Than

This block is a combinational arithmetic logic unit. It is built from a row of identical one-bit slices. Each slice forms the AND, the OR and a full-adder sum of its two operand bits. A two-bit select picks one of these three, or a fourth input named "less", as the slice output. The carry-out of each slice drives the carry-in of the slice above it, so the carry ripples up the row. Subtraction needs no separate subtractor. One shared line inverts every B bit, and the same line forces a 1 into the carry of the lowest slice.

A three-bit control code chooses the operation. The upper control bit drives the B inversion and the lowest carry-in. The lower two bits choose the slice output. For set-less-than, the raw adder sum of the top slice (the sign of A − B) is fed back into the "less" input of bit 0. The "less" inputs of all other slices are tied low. The unit also reports three flags: a zero flag for the result, a signed overflow flag and the adder carry-out.

Top module: `slice_alu`

## Requirements
- R1: Control code 3'b000 gives the bitwise AND of A and B.
- R2: Control code 3'b001 gives the bitwise OR of A and B.
- R3: Control code 3'b010 gives A + B modulo 2^32, and carry_out is the carry leaving bit 31.
- R4: Control code 3'b110 gives A + ~B + 1, which is A − B modulo 2^32. carry_out is the carry leaving bit 31, so it is 1 when no borrow occurs.
- R5: Control code 3'b111 gives a result whose bit 0 equals bit 31 of the wrapped difference A − B, with bits 31..1 at zero. This sign is not corrected for overflow. For example, A=0x80000000 and B=1 give 0.
- R6: For codes 010, 110 and 111, overflow is the carry into bit 31 XOR the carry out of bit 31. It is therefore 1 exactly when a signed add or subtract leaves the representable range.
- R7: zero is 1 exactly when all 32 result bits are 0, for every control code.
- R8: For codes 000 and 001, overflow and carry_out are both 0.
- R9: The unused codes 011, 100 and 101 give a result of all zeros, with overflow and carry_out at 0 (so zero is 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | 32 | Operand A |
| opnd_b | input | 32 | Operand B |
| ctrl | input | 3 | Operation code |
| result | output | 32 | Operation result |
| zero | output | 1 | Result is all zeros |
| overflow | output | 1 | Signed overflow of add, subtract or compare |
| carry_out | output | 1 | Carry leaving the top slice |

## Verification
Random operand pairs across all eight control codes exercise the ripple chain and the select path broadly. Directed operands are aimed at the sign boundaries: 0x7FFFFFFF + 1 and 0x80000000 − 1 separate a correct carry-into-MSB overflow test from a sign-only test. Compares that overflow (0x80000000 against 1) show that the raw top sum, not a corrected sign, reaches bit 0. Adds of 0xFFFFFFFF + 1 and subtracts of equal operands expose carry_out and the zero flag, and the unused codes show that the masking removes the adder output and both arithmetic flags.

// File: rtl/slice_alu_pkg.sv
package slice_alu_pkg;

    typedef enum logic [1:0] {
        SEL_AND  = 2'b00,
        SEL_OR   = 2'b01,
        SEL_SUM  = 2'b10,
        SEL_LESS = 2'b11
    } slice_sel_e;

    localparam logic [2:0] CODE_AND = 3'b000;
    localparam logic [2:0] CODE_OR  = 3'b001;
    localparam logic [2:0] CODE_ADD = 3'b010;
    localparam logic [2:0] CODE_SUB = 3'b110;
    localparam logic [2:0] CODE_SLT = 3'b111;

    typedef struct packed {
        logic       valid;
        logic       invert_b;
        slice_sel_e sel;
    } alu_ctl_t;

endpackage

// File: rtl/slice_alu_decode.sv
module slice_alu_decode
    import slice_alu_pkg::*;
(
    input  logic [2:0] ctrl,
    output alu_ctl_t   ctl
);
    alu_ctl_t ctl_d;

    always_comb begin
        ctl_d.invert_b = ctrl[2];
        ctl_d.sel      = slice_sel_e'(ctrl[1:0]);
        case (ctrl)
            CODE_AND, CODE_OR, CODE_ADD, CODE_SUB, CODE_SLT: ctl_d.valid = 1'b1;
            default:                                         ctl_d.valid = 1'b0;
        endcase
    end

    assign ctl = ctl_d;
endmodule

// File: rtl/slice_alu_bit.sv
module slice_alu_bit
    import slice_alu_pkg::*;
(
    input  logic       a,
    input  logic       b,
    input  logic       invert_b,
    input  logic       carry_in,
    input  logic       less,
    input  slice_sel_e sel,
    output logic       res,
    output logic       sum,
    output logic       carry_out
);
    logic b_eff;

    always_comb begin
        b_eff     = b ^ invert_b;
        sum       = a ^ b_eff ^ carry_in;
        carry_out = (a & b_eff) | (a & carry_in) | (b_eff & carry_in);
        case (sel)
            SEL_AND: res = a & b;
            SEL_OR:  res = a | b;
            SEL_SUM: res = sum;
            default: res = less;
        endcase
    end
endmodule

// File: rtl/slice_alu.sv
module slice_alu
    import slice_alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic [2:0]       ctrl,
    output logic [WIDTH-1:0] result,
    output logic             zero,
    output logic             overflow,
    output logic             carry_out
);
    localparam int MSB = WIDTH - 1;

    typedef struct packed {
        logic [WIDTH-1:0] result;
        logic             zero;
        logic             overflow;
        logic             carry;
    } alu_out_t;

    alu_ctl_t         ctl;
    logic [WIDTH:0]   carry_chain;
    logic [WIDTH-1:0] slice_res;
    logic [WIDTH-1:0] slice_sum;
    logic [WIDTH-1:0] less_v;
    alu_out_t         out_d;

    slice_alu_decode u_decode (
        .ctrl (ctrl),
        .ctl  (ctl)
    );

    assign carry_chain[0] = ctl.invert_b;
    assign less_v         = {{(WIDTH-1){1'b0}}, slice_sum[MSB]};

    for (genvar i = 0; i < WIDTH; i++) begin : g_slice
        slice_alu_bit u_bit (
            .a         (opnd_a[i]),
            .b         (opnd_b[i]),
            .invert_b  (ctl.invert_b),
            .carry_in  (carry_chain[i]),
            .less      (less_v[i]),
            .sel       (ctl.sel),
            .res       (slice_res[i]),
            .sum       (slice_sum[i]),
            .carry_out (carry_chain[i+1])
        );
    end

    always_comb begin
        logic arith;
        arith          = ctl.valid && (ctl.sel == SEL_SUM || ctl.sel == SEL_LESS);
        out_d.result   = ctl.valid ? slice_res : '0;
        out_d.zero     = (out_d.result == '0);
        out_d.overflow = arith & (carry_chain[WIDTH] ^ carry_chain[MSB]);
        out_d.carry    = arith & carry_chain[WIDTH];
    end

    assign result    = out_d.result;
    assign zero      = out_d.zero;
    assign overflow  = out_d.overflow;
    assign carry_out = out_d.carry;

    always_comb begin
        if (ctrl == CODE_ADD)
            AST_ADD_CHAIN: assert ({carry_out, result} == ({1'b0, opnd_a} + {1'b0, opnd_b})); // R3
        if (ctrl == CODE_SUB)
            AST_SUB_DIFF: assert (result == opnd_a - opnd_b); // R4
        if (ctrl == CODE_SLT)
            AST_SLT_UPPER: assert (result[MSB:1] == '0); // R5
        if (ctrl == CODE_AND || ctrl == CODE_OR)
            AST_LOGIC_FLAGS: assert (!overflow && !carry_out); // R8
        if (ctrl == 3'b011 || ctrl == 3'b100 || ctrl == 3'b101)
            AST_UNUSED_CLEAR: assert (zero && !overflow && !carry_out); // R9
    end
endmodule

// File: tb/slice_alu_bench.sv
`timescale 1ns/1ps
module slice_alu_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] a_i = '0;
    logic [31:0] b_i = '0;
    logic [2:0]  c_i = '0;
    logic [31:0] res_o;
    logic        zero_o, ovf_o, cout_o;
    int          checks = 0;
    int          errors = 0;
    bit          done   = 1'b0;

    always #2.5 clk = ~clk;

    slice_alu u_slice_alu (
        .opnd_a    (a_i),
        .opnd_b    (b_i),
        .ctrl      (c_i),
        .result    (res_o),
        .zero      (zero_o),
        .overflow  (ovf_o),
        .carry_out (cout_o)
    );

    // expected {result, zero, overflow, carry_out}
    function automatic logic [34:0] model(input logic [31:0] a, input logic [31:0] b,
                                          input logic [2:0] c);
        logic [32:0] s;
        logic [31:0] r;
        logic        ov, co;
        r = '0; ov = 1'b0; co = 1'b0;
        case (c)
            3'b000: r = a & b;
            3'b001: r = a | b;
            3'b010: begin
                s = {1'b0, a} + {1'b0, b};
                r = s[31:0]; co = s[32];
                ov = (a[31] == b[31]) && (r[31] != a[31]);
            end
            3'b110, 3'b111: begin
                s = {1'b0, a} + {1'b0, ~b} + 33'd1;
                co = s[32];
                ov = (a[31] != b[31]) && (s[31] != a[31]);
                r = (c == 3'b110) ? s[31:0] : {31'd0, s[31]};
            end
            default: ;
        endcase
        return {r, (r == '0), ov, co};
    endfunction

    function automatic string tag_of(input logic [2:0] c);
        case (c)
            3'b000:  return "R1";
            3'b001:  return "R2";
            3'b010:  return "R3";
            3'b110:  return "R4";
            3'b111:  return "R5";
            default: return "R9";
        endcase
    endfunction

    task automatic run(input logic [31:0] a, input logic [31:0] b, input logic [2:0] c,
                       input string tag);
        logic [34:0] exp_v, act_v;
        @(negedge clk);
        a_i = a; b_i = b; c_i = c;
        @(posedge clk);
        #1;
        exp_v = model(a, b, c);
        act_v = {res_o, zero_o, ovf_o, cout_o};
        checks++;
        if (act_v !== exp_v) begin
            errors++;
            $display("FAIL %s ctrl=%b a=%h b=%h actual res=%h z=%b v=%b c=%b expected res=%h z=%b v=%b c=%b",
                     tag, c, a, b, act_v[34:3], act_v[2], act_v[1], act_v[0],
                     exp_v[34:3], exp_v[2], exp_v[1], exp_v[0]);
        end
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // reset state: idle inputs, R7 zero flag high on zero AND
        run(32'h0, 32'h0, 3'b000, "R7");
        run(32'hF0F0_1234, 32'h0FF0_FFFF, 3'b000, "R1");
        run(32'hF0F0_1234, 32'h0F00_0001, 3'b001, "R2");
        run(32'hFFFF_FFFF, 32'hFFFF_FFFF, 3'b001, "R8");
        run(32'h7FFF_FFFF, 32'h0000_0001, 3'b010, "R6");
        run(32'hFFFF_FFFF, 32'h0000_0001, 3'b010, "R3");
        run(32'h8000_0000, 32'h8000_0000, 3'b010, "R6");
        run(32'h8000_0000, 32'h0000_0001, 3'b110, "R6");
        run(32'h1234_5678, 32'h1234_5678, 3'b110, "R7");
        run(32'h0000_0000, 32'h0000_0001, 3'b110, "R4");
        run(32'hFFFF_FFFC, 32'h0000_0001, 3'b111, "R5");
        run(32'h8000_0000, 32'h0000_0001, 3'b111, "R5");
        run(32'h0000_0005, 32'h0000_0005, 3'b111, "R5");
        run(32'h7FFF_FFFF, 32'hFFFF_FFFF, 3'b111, "R6");
        run(32'hFFFF_FFFF, 32'h0000_0001, 3'b011, "R9");
        run(32'hFFFF_FFFF, 32'hFFFF_FFFF, 3'b100, "R9");
        run(32'h1234_5678, 32'h8765_4321, 3'b101, "R9");
        for (int i = 0; i < 400; i++) begin
            logic [2:0] c;
            c = 3'($urandom_range(0, 7));
            run($urandom, $urandom, c, tag_of(c));
        end
        for (int i = 0; i < 40; i++) begin
            logic [31:0] a;
            a = {$urandom_range(0, 1) ? 1'b1 : 1'b0, 31'($urandom)};
            run(a, a ^ 32'h8000_0000, 3'b110, "R6");
            run(a, a, 3'b111, "R5");
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule